// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the external-bus control timing for an 8-bit controller core whose machine cycle lasts twelve oscillator clocks. Once per machine cycle it samples the core's requests: an instruction fetch at a program-counter value, or a data read or write at a 16-bit address. It then plays out a fixed twelve-clock pattern on the address latch strobe (`ale`), the active-low program-store strobe (`psen_n`), the active-low data strobes (`rd_n`, `wr_n`), the shared low address/data byte (`ad_out` with `ad_oe`) and the high address byte (`addr_hi`).

Fetches are served internally when `ext_en` is high and the program counter is at or below the internal limit (0x0FFF by default). They go to the external bus when the counter lies above that limit or `ext_en` is low. An external fetch reads two bytes, at `pc` and `pc+1`. A data cycle replaces the fetch pattern: its second address strobe and both program-store strobes are dropped. The block also filters the device reset pin, which takes effect only after being held high for two whole machine cycles.

`rst_n` is the block's own asynchronous reset and is assumed to be already synchronised to `clk`. Numbering used below: the outputs of a machine cycle occupy the twelve clock periods that start one period after the clock edge that samples its requests; these periods are called k=0..11.

Top module: `xbus_strobe_seq`

## Requirements
- R1: `ale` is high exactly in k=1, 2, 7 and 8 of every fetch or no-request machine cycle. That gives two pulses, each two clocks wide, per twelve clocks.
- R2: In a data read or write cycle, `ale` is high only in k=1 and 2. The second pulse is suppressed.
- R3: In an external fetch cycle, `psen_n` is low exactly in k=3..5 and k=9..11.
- R4: `psen_n` stays high for the whole of a data cycle, and it is never low while `rd_n` or `wr_n` is low.
- R5: A fetch is internal when `ext_en`=1 and `pc`<=0x0FFF. An internal fetch leaves `psen_n` high and `ad_oe` low all cycle. A fetch with `pc`>0x0FFF or `ext_en`=0 is external.
- R6: In an external fetch, `ad_oe` is high in k=0..2, with `ad_out`=`pc[7:0]`, and in k=6..8, with `ad_out`=(`pc`+1)[7:0]. `addr_hi` is `pc[15:8]` in k=0..5 and (`pc`+1)[15:8] in k=6..11. The bus floats at all other k.
- R7: In a data read, `ad_out`=`dm_addr[7:0]` with `ad_oe` high in k=0..2, and the bus floats in k=3..11. `rd_n` is low in k=4..6. `addr_hi`=`dm_addr[15:8]` in every k. `rd_valid` is high in k=7 only, and `rd_data` then holds `ad_in` as sampled at the end of k=6.
- R8: In a data write, `ad_oe` is high in all of k=0..11. `ad_out`=`dm_addr[7:0]` in k=0..2 and `dm_wdata` in k=3..11. `wr_n` is low in k=4..6, and `addr_hi`=`dm_addr[15:8]`.
- R9: Requests are sampled only at the clock edge that ends a period where `cyc_end` is high. Read takes priority over write, and write over fetch. With no request, the cycle drives no strobe other than `ale`.
- R10: `core_rst` rises after `rst_pin` has been sampled high on 24 consecutive clock edges (two machine cycles). A shorter high pulse never raises it. It falls at the first edge that samples `rst_pin` low.
- R11: While `core_rst` is high, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe` is low and `cyc_end` is high. The edge that releases it samples the requests for the first new machine cycle.
- R12: While `rst_n` is low, the outputs take the same idle levels, `core_rst` and `rd_valid` are low, and `cyc_end` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| rst_pin | input | 1 | Device reset pin level, active high, filtered |
| ext_en | input | 1 | High lets low program addresses be fetched internally |
| pc | input | 16 | Program counter for the fetch request |
| fetch_req | input | 1 | Instruction fetch requested for the next machine cycle |
| rd_req | input | 1 | External data read requested |
| wr_req | input | 1 | External data write requested |
| dm_addr | input | 16 | Data-memory address |
| dm_wdata | input | 8 | Data-memory write byte |
| ad_in | input | 8 | Byte read back from the multiplexed bus |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Multiplexed low address / write data |
| ad_oe | output | 1 | Drive enable for the multiplexed bus |
| addr_hi | output | 8 | High address byte |
| rd_data | output | 8 | Byte captured by the last data read |
| rd_valid | output | 1 | One-clock pulse when rd_data is updated |
| cyc_end | output | 1 | Last clock of a machine cycle; requests sampled at its end |
| core_rst | output | 1 | Filtered device reset for the core |

## Verification
The assertions take for granted that `rst_n` comes out of reset synchronously and that request inputs are stable around the edge that closes a `cyc_end` period. They do not assume the strobe pattern any request leads to; they only check that the strobes exclude each other and keep the bus direction consistent. The reset-length property assumes `rst_pin` is a clean synchronous level, which the stimulus honours by changing every input only at falling clock edges. The stimulus changes requests only in a `cyc_end` period, and drops them immediately after the sampling edge, so that any late sampling would show up as a wrong pattern.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  localparam int MC_CLKS = 12;                 // clocks per machine cycle
  localparam int PH_W    = $clog2(MC_CLKS);
  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;

  // phase positions inside a machine cycle (decoder view)
  localparam int PH_LAST    = MC_CLKS - 1;
  localparam int PH_ALE_A   = 1;
  localparam int PH_ALE_B   = 7;
  localparam int ALE_LEN    = 2;
  localparam int PH_ADR_END = 2;
  localparam int PH_HALF    = MC_CLKS / 2;
  localparam int HALF_ADR   = 3;
  localparam int PH_PS_A    = 3;
  localparam int PH_PS_B    = 9;
  localparam int PS_LEN     = 3;
  localparam int PH_STB     = 4;
  localparam int STB_LEN    = 3;
  localparam int PH_CAP     = PH_STB + STB_LEN;

  typedef enum logic [2:0] {
    CK_NOP, CK_FINT, CK_FEXT, CK_DRD, CK_DWR
  } cyc_kind_e;

  typedef struct packed {
    logic              ale;
    logic              psen_n;
    logic              rd_n;
    logic              wr_n;
    logic              oe;
    logic [BYTE_W-1:0] ad;
    logic [BYTE_W-1:0] hi;
    logic              hi_ld;
    logic              cap;
  } bus_drv_t;

  function automatic logic in_win(input logic [PH_W-1:0] ph, input int st, input int len);
    return (int'(ph) >= st) && (int'(ph) < st + len);
  endfunction

endpackage

// File: rtl/xbs_rst_filter.sv
module xbs_rst_filter #(
  parameter int RST_CLKS = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  output logic core_rst_d,
  output logic core_rst_q
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LIM    = CW'(RST_CLKS);
  localparam logic [CW-1:0] LIM_M1 = CW'(RST_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!rst_pin)          cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
    core_rst_d = rst_pin && (cnt_q >= LIM_M1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      core_rst_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      core_rst_q <= core_rst_d;
    end
  end
endmodule

// File: rtl/xbs_cycle_ctl.sv
module xbs_cycle_ctl
  import xbs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_rst,
  input  logic              ext_en,
  input  logic [ADDR_W-1:0] pc,
  input  logic              fetch_req,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] dm_addr,
  input  logic [BYTE_W-1:0] dm_wdata,
  output logic [PH_W-1:0]   phase,
  output cyc_kind_e         kind,
  output logic [ADDR_W-1:0] addr0,
  output logic [ADDR_W-1:0] addr1,
  output logic [BYTE_W-1:0] wdat,
  output logic              cyc_end
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PH_LAST);

  logic [PH_W-1:0]   ph_q, ph_d;
  cyc_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] a0_q, a0_d, a1_q, a1_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic              ld_en, fetch_ext;

  assign fetch_ext = !ext_en || (pc > INT_TOP);
  assign ld_en     = (ph_q == LAST) && !core_rst;

  always_comb begin
    ph_d   = core_rst ? LAST : ((ph_q == LAST) ? '0 : ph_q + 1'b1);
    kind_d = kind_q;
    a0_d   = a0_q;
    a1_d   = a1_q;
    wd_d   = wd_q;
    if (core_rst) begin
      kind_d = CK_NOP;
    end else if (ld_en) begin
      a1_d = pc + 1'b1;
      wd_d = dm_wdata;
      if (rd_req || wr_req) a0_d = dm_addr;
      else                  a0_d = pc;
      if (rd_req)         kind_d = CK_DRD;
      else if (wr_req)    kind_d = CK_DWR;
      else if (fetch_req) kind_d = fetch_ext ? CK_FEXT : CK_FINT;
      else                kind_d = CK_NOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= LAST;
      kind_q <= CK_NOP;
      a0_q   <= '0;
      a1_q   <= '0;
      wd_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
      a0_q   <= a0_d;
      a1_q   <= a1_d;
      wd_q   <= wd_d;
    end
  end

  assign phase   = ph_q;
  assign kind    = kind_q;
  assign addr0   = a0_q;
  assign addr1   = a1_q;
  assign wdat    = wd_q;
  assign cyc_end = (ph_q == LAST);
endmodule

// File: rtl/xbs_strobe_dec.sv
module xbs_strobe_dec
  import xbs_pkg::*;
(
  input  logic [PH_W-1:0]   phase,
  input  cyc_kind_e         kind,
  input  logic [ADDR_W-1:0] addr0,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [BYTE_W-1:0] wdat,
  output bus_drv_t          drv
);
  logic is_data, ale_a, ale_b, adr_ph, upper;

  always_comb begin
    is_data = (kind == CK_DRD) || (kind == CK_DWR);
    ale_a   = in_win(phase, PH_ALE_A, ALE_LEN);
    ale_b   = in_win(phase, PH_ALE_B, ALE_LEN);
    adr_ph  = int'(phase) <= PH_ADR_END;
    upper   = int'(phase) >= PH_HALF;

    drv        = '0;
    drv.psen_n = 1'b1;
    drv.rd_n   = 1'b1;
    drv.wr_n   = 1'b1;
    drv.ale    = (kind != CK_NOP || int'(phase) != PH_LAST) &&
                 (ale_a || (ale_b && !is_data));

    unique case (kind)
      CK_FEXT: begin
        drv.psen_n = !(in_win(phase, PH_PS_A, PS_LEN) || in_win(phase, PH_PS_B, PS_LEN));
        drv.oe     = adr_ph || in_win(phase, PH_HALF, HALF_ADR);
        drv.ad     = upper ? addr1[BYTE_W-1:0]      : addr0[BYTE_W-1:0];
        drv.hi     = upper ? addr1[ADDR_W-1:BYTE_W] : addr0[ADDR_W-1:BYTE_W];
        drv.hi_ld  = 1'b1;
      end
      CK_DRD: begin
        drv.oe    = adr_ph;
        drv.ad    = addr0[BYTE_W-1:0];
        drv.rd_n  = !in_win(phase, PH_STB, STB_LEN);
        drv.hi    = addr0[ADDR_W-1:BYTE_W];
        drv.hi_ld = 1'b1;
        drv.cap   = (int'(phase) == PH_CAP);
      end
      CK_DWR: begin
        drv.oe    = 1'b1;
        drv.ad    = adr_ph ? addr0[BYTE_W-1:0] : wdat;
        drv.wr_n  = !in_win(phase, PH_STB, STB_LEN);
        drv.hi    = addr0[ADDR_W-1:BYTE_W];
        drv.hi_ld = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbs_pkg::*;
#(
  parameter logic [15:0] INT_TOP = 16'h0FFF,
  parameter int          RST_MC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_pin,
  input  logic        ext_en,
  input  logic [15:0] pc,
  input  logic        fetch_req,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [15:0] dm_addr,
  input  logic [7:0]  dm_wdata,
  input  logic [7:0]  ad_in,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  addr_hi,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        cyc_end,
  output logic        core_rst
);
  localparam int RST_CLKS = RST_MC * MC_CLKS;

  logic              crst_d;
  logic [PH_W-1:0]   phase;
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] addr0, addr1;
  logic [BYTE_W-1:0] wdat;
  bus_drv_t          drv;

  xbs_rst_filter #(.RST_CLKS(RST_CLKS)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin),
    .core_rst_d(crst_d), .core_rst_q(core_rst)
  );

  xbs_cycle_ctl #(.INT_TOP(INT_TOP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .core_rst(crst_d), .ext_en(ext_en), .pc(pc),
    .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .phase(phase), .kind(kind), .addr0(addr0), .addr1(addr1),
    .wdat(wdat), .cyc_end(cyc_end)
  );

  xbs_strobe_dec u_dec (
    .phase(phase), .kind(kind), .addr0(addr0), .addr1(addr1),
    .wdat(wdat), .drv(drv)
  );

  // registered pin stage
  logic              ale_q, ale_d, psen_q, psen_d, rd_q, rd_d, wr_q, wr_d;
  logic              oe_q, oe_d, vld_q, vld_d;
  logic [BYTE_W-1:0] ad_q, ad_d, hi_q, hi_d, rdat_q, rdat_d;

  always_comb begin
    ale_d  = !crst_d && drv.ale;
    psen_d =  crst_d || drv.psen_n;
    rd_d   =  crst_d || drv.rd_n;
    wr_d   =  crst_d || drv.wr_n;
    oe_d   = !crst_d && drv.oe;
    ad_d   = crst_d ? '0 : drv.ad;
    hi_d   = (!crst_d && drv.hi_ld) ? drv.hi : hi_q;
    vld_d  = !crst_d && drv.cap;
    rdat_d = (!crst_d && drv.cap) ? ad_in : rdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      psen_q <= 1'b1;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      oe_q   <= 1'b0;
      ad_q   <= '0;
      hi_q   <= '0;
      vld_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ale_q  <= ale_d;
      psen_q <= psen_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      oe_q   <= oe_d;
      ad_q   <= ad_d;
      hi_q   <= hi_d;
      vld_q  <= vld_d;
      rdat_q <= rdat_d;
    end
  end

  assign ale      = ale_q;
  assign psen_n   = psen_q;
  assign rd_n     = rd_q;
  assign wr_n     = wr_q;
  assign ad_oe    = oe_q;
  assign ad_out   = ad_q;
  assign addr_hi  = hi_q;
  assign rd_valid = vld_q;
  assign rd_data  = rdat_q;
endmodule

// File: rtl/xbs_chk.sv
module xbs_chk #(
  parameter int RST_CLKS = 24
) (
  input logic clk,
  input logic rst_n,
  input logic rst_pin,
  input logic core_rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_CLKS);

  logic [CW-1:0] pin_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pin_cnt <= '0;
    else if (!rst_pin)     pin_cnt <= '0;
    else if (pin_cnt != LIM) pin_cnt <= pin_cnt + 1'b1;
  end

  p_idle_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));

  p_psen_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> (rd_n && wr_n));

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> wr_n);

  p_rd_floats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_wr_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  p_ale_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);

  p_rst_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> (pin_cnt >= LIM));

  p_rst_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin |=> !core_rst);
endmodule

bind xbus_strobe_seq xbs_chk #(.RST_CLKS(RST_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .core_rst(core_rst),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe)
);

// File: tb/sim_xbus_strobe_seq.sv
`timescale 1ns/1ps
module sim_xbus_strobe_seq;
  logic clk = 1'b0;
  logic rst_n, rst_pin, ext_en, fetch_req, rd_req, wr_req;
  logic [15:0] pc, dm_addr;
  logic [7:0]  dm_wdata, ad_in;
  logic ale, psen_n, rd_n, wr_n, ad_oe, rd_valid, cyc_end, core_rst;
  logic [7:0] ad_out, addr_hi, rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;   // 125 MHz

  xbus_strobe_seq u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ext_en(ext_en), .pc(pc),
    .fetch_req(fetch_req), .rd_req(rd_req), .wr_req(wr_req),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
    .rd_data(rd_data), .rd_valid(rd_valid), .cyc_end(cyc_end), .core_rst(core_rst)
  );

  // captured outputs of one machine cycle, index k = 0..11
  logic c_ale[12], c_psen[12], c_rd[12], c_wr[12], c_oe[12], c_vld[12];
  logic [7:0] c_ad[12], c_hi[12];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive a request in a cyc_end period, capture the resulting 12 periods
  task automatic launch(input bit f, input bit r, input bit w, input bit ea,
                        input logic [15:0] p, input logic [15:0] a, input logic [7:0] wd);
    do @(negedge clk); while (!cyc_end);
    fetch_req = f; rd_req = r; wr_req = w; ext_en = ea;
    pc = p; dm_addr = a; dm_wdata = wd;
    @(negedge clk);
    fetch_req = 0; rd_req = 0; wr_req = 0;
    pc = 16'h5A5A; dm_addr = 16'hA5A5; dm_wdata = 8'h3C;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      c_ale[k] = ale;   c_psen[k] = psen_n; c_rd[k] = rd_n; c_wr[k] = wr_n;
      c_oe[k]  = ad_oe; c_ad[k]   = ad_out; c_hi[k] = addr_hi; c_vld[k] = rd_valid;
    end
  endtask

  // kind: 0 no bus, 1 external fetch, 2 data read, 3 data write
  task automatic check_cycle(input int kind, input logic [15:0] a0, input logic [15:0] a1,
                             input logic [7:0] wd, input string req);
    bit ok[7];
    int ka[7], ke[7], kk[7];
    string nm[7] = '{"ale", "psen_n", "rd_n", "wr_n", "ad_oe", "ad_out", "addr_hi"};
    for (int s = 0; s < 7; s++) ok[s] = 1;
    for (int k = 0; k < 12; k++) begin
      int e[7], a[7];
      bit e_oe;
      e[0] = int'((k == 1 || k == 2) || ((k == 7 || k == 8) && kind < 2));
      e[1] = int'(!(kind == 1 && ((k >= 3 && k <= 5) || k >= 9)));
      e[2] = int'(!(kind == 2 && k >= 4 && k <= 6));
      e[3] = int'(!(kind == 3 && k >= 4 && k <= 6));
      e_oe = (kind == 1) ? (k <= 2 || (k >= 6 && k <= 8)) :
             (kind == 2) ? (k <= 2) : (kind == 3);
      e[4] = int'(e_oe);
      if (!e_oe)          e[5] = 0;
      else if (kind == 1) e[5] = (k < 6) ? int'(a0[7:0]) : int'(a1[7:0]);
      else if (kind == 3) e[5] = (k < 3) ? int'(a0[7:0]) : int'(wd);
      else                e[5] = int'(a0[7:0]);
      e[6] = (kind == 1 && k >= 6) ? int'(a1[15:8]) : int'(a0[15:8]);
      a[0] = int'(c_ale[k]); a[1] = int'(c_psen[k]); a[2] = int'(c_rd[k]);
      a[3] = int'(c_wr[k]);  a[4] = int'(c_oe[k]);
      a[5] = e_oe ? int'(c_ad[k]) : 0;
      a[6] = int'(c_hi[k]);
      for (int s = 0; s < 7; s++)
        if (ok[s] && a[s] != e[s]) begin ok[s] = 0; ka[s] = a[s]; ke[s] = e[s]; kk[s] = k; end
    end
    for (int s = 0; s < 7; s++)
      if (!(s == 6 && kind == 0))
        check(ok[s], req, $sformatf("%s k=%0d", nm[s], kk[s]), ka[s], ke[s]);
  endtask

  task automatic t_reset_state;
    check(ale == 0 && psen_n == 1 && rd_n == 1 && wr_n == 1 && ad_oe == 0,
          "R12", "idle strobes after rst_n", {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    check(core_rst == 0 && rd_valid == 0 && cyc_end == 1, "R12", "core_rst/rd_valid/cyc_end",
          {core_rst, rd_valid, cyc_end}, 3'b001);
  endtask

  task automatic t_ext_fetch(input logic [15:0] p, input bit ea, input string req);
    launch(1, 0, 0, ea, p, 16'h0000, 8'h00);
    check_cycle(1, p, p + 16'd1, 8'h00, req);
  endtask

  task automatic t_int_fetch(input logic [15:0] p);
    launch(1, 0, 0, 1, p, 16'h0000, 8'h00);
    check_cycle(0, p, p, 8'h00, "R5");
  endtask

  task automatic t_nop;
    launch(0, 0, 0, 0, 16'h2000, 16'h0000, 8'h00);
    check_cycle(0, 16'h0, 16'h0, 8'h00, "R1/R9");
  endtask

  task automatic t_read(input logic [15:0] a, input logic [7:0] d, input bit also_w, input string req);
    ad_in = d;
    launch(1, 1, also_w, 0, 16'h3333, a, 8'hEE);
    check_cycle(2, a, a, 8'h00, req);
    begin
      bit vok = 1;
      for (int k = 0; k < 12; k++) if (c_vld[k] != (k == 7)) vok = 0;
      check(vok, "R7", "rd_valid only at k=7", int'(c_vld[7]), 1);
    end
    check(rd_data == d, "R7", "rd_data", int'(rd_data), int'(d));
    ad_in = 8'h00;
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d, input string req);
    launch(1, 0, 1, 0, 16'h4444, a, d);
    check_cycle(3, a, a, d, req);
  endtask

  task automatic t_rst_short;
    bit ok = 1;
    @(negedge clk);
    rst_pin = 1;
    for (int i = 1; i <= 23; i++) begin
      @(negedge clk);
      if (core_rst) ok = 0;
    end
    rst_pin = 0;
    @(negedge clk);
    if (core_rst) ok = 0;
    check(ok, "R10", "core_rst after 23-clock pulse", int'(core_rst), 0);
  endtask

  task automatic t_rst_long;
    bit early_ok = 1, set_ok = 1, idle_ok = 1;
    @(negedge clk);
    fetch_req = 1; ext_en = 0; pc = 16'h1234; wr_req = 1; dm_wdata = 8'h77;
    rst_pin = 1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i < 24 && core_rst) early_ok = 0;
      if (i >= 24 && !core_rst) set_ok = 0;
      if (i >= 24 && (ale || !psen_n || !rd_n || !wr_n || ad_oe || !cyc_end)) idle_ok = 0;
    end
    check(early_ok, "R10", "core_rst before 24 edges", 1, 0);
    check(set_ok, "R10", "core_rst from edge 24", int'(core_rst), 1);
    check(idle_ok, "R11", "idle outputs in core_rst", {ale, psen_n, ad_oe}, 3'b010);
    fetch_req = 0; wr_req = 0;
    rst_pin = 0;
    @(negedge clk);
    check(!core_rst, "R10", "core_rst drops with pin", int'(core_rst), 0);
    t_ext_fetch(16'h0123, 0, "R11");
  endtask

  initial begin
    rst_n = 0; rst_pin = 0; ext_en = 1; fetch_req = 0; rd_req = 0; wr_req = 0;
    pc = 16'h0; dm_addr = 16'h0; dm_wdata = 8'h0; ad_in = 8'h0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;

    t_ext_fetch(16'h1000, 1, "R1/R3/R5/R6");   // just above internal limit
    t_ext_fetch(16'h0010, 0, "R3/R5/R6");      // ext_en low forces external
    t_ext_fetch(16'hFFFF, 1, "R6");            // pc+1 wraps to 0000
    t_int_fetch(16'h0FFF);                     // R5 boundary stays internal
    t_int_fetch(16'h0000);
    t_nop();
    t_read(16'hBEEF, 8'h96, 0, "R2/R4/R7");
    t_write(16'h12C4, 8'h5B, "R2/R4/R8");
    t_read(16'h00FF, 8'h41, 1, "R9");          // read beats write and fetch
    t_write(16'hFE01, 8'hA0, "R9");            // write beats fetch
    t_rst_short();
    t_ext_fetch(16'h8421, 1, "R10");
    t_rst_long();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule